// File: doc/BRIEF.md
# DAC Channel Sample Source Multiplexer

This block picks the sample stream that one DAC channel sends to the converter. A 4-bit source code chooses among the tone generator output, a pair of alternating fixed words, streamed memory data, constant zero, two pseudo-random bit sequences (each in true or complemented form), ADC loopback data, an externally generated device-specific pseudo-random stream, and two ramps. The pseudo-random, pattern and ramp generators are built in. They advance on every valid sample whatever source is selected.

Two override inputs can replace the programmed code without rewriting it. One forces loopback and the other forces the external pseudo-random stream. When both are raised together, neither applies. A complex mode treats the chosen stream as interleaved I/Q pairs and emits each pair after it has been fully received. A swap control reverses the order within each pair, but only in complex mode.

The output is registered. `out_valid` follows `in_valid` by one clock, and `out_data` changes only on cycles that carry a valid sample.

Top module: `dac_src_sel`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals `in_valid` one clock later. `out_data` keeps its value through any cycle without `in_valid`.
- R3: With no override and complex mode off, a valid sample produces a result on the next clock as follows. Code 0x0 gives `dds_data`, 0x2 gives `dma_data`, 0x3 gives zero, 0x8 gives `lpbk_data` and 0x9 gives `pnx_data`. Codes 0xC through 0xF give zero.
- R4: Code 0x1 returns `pat_a` and `pat_b` on alternating valid samples. The first valid sample after reset gets `pat_a`.
- R5: Code 0x6 gives a 7-bit LFSR state in bits [6:0], with the upper bits zero. The register is seeded with all ones. Each valid sample it shifts left and brings in bit6 XOR bit5 at bit 0 (x^7+x^6+1). Code 0x4 gives the bitwise complement of the full 16-bit code-0x6 word.
- R6: Code 0x7 gives a 15-bit LFSR state in bits [14:0], with bit 15 zero. The register is seeded with all ones and shifts left each valid sample, taking bit14 XOR bit13 into bit 0 (x^15+x^14+1). Code 0x5 gives the complement of the 16-bit code-0x7 word.
- R7: Code 0xA gives a 4-bit count that starts at 0 and repeats in every nibble of the sample. The count rises by 1 per valid sample and wraps from 0xF to 0x0.
- R8: Code 0xB gives a 16-bit count that starts at 0, rises by 1 per valid sample and wraps from 0xFFFF to 0x0000.
- R9: With only `ovr_lpbk` high, code 0x8 applies regardless of `sel`.
- R10: With only `ovr_pnx` high, code 0x9 applies regardless of `sel`.
- R11: With both override bits high, both are ignored and `sel` applies.
- R12: All generators advance on every valid sample, including samples taken while another source is selected.
- R13: In complex mode, the valid samples from the mode's start alternate I, Q. The I and Q of pair m come out on the two valid samples of pair m+1, in I-then-Q order. Before the first pair is complete, the output is zero after a reset. Leaving complex mode restarts the I/Q alternation.
- R14: In complex mode with `iq_swap` high, each emitted pair comes out Q first. With complex mode off, `iq_swap` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new sample is taken this cycle |
| sel | input | 4 | Programmed source code |
| ovr_lpbk | input | 1 | Force loopback source |
| ovr_pnx | input | 1 | Force external pseudo-random source |
| pat_a | input | 16 | First fixed pattern word |
| pat_b | input | 16 | Second fixed pattern word |
| dds_data | input | 16 | Tone generator sample |
| dma_data | input | 16 | Streamed memory sample |
| lpbk_data | input | 16 | ADC loopback sample |
| pnx_data | input | 16 | External pseudo-random sample |
| iq_mode | input | 1 | Complex I/Q pairing enable |
| iq_swap | input | 1 | Emit Q before I within each pair |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Selected sample to the DAC |

## Verification
The pass-through sources are driven with a per-cycle data word, and each input port gets a different XOR of that word. A wrong mux leg therefore shows up as a wrong value and cannot pass by coincidence. Idle cycles are mixed into the stimulus, and the inputs change during them, to separate hold behaviour from capture. The generators run through long stretches, including a full 65,536-sample ramp wrap and more than 16 nibble steps. Switches between sources show that hidden state kept advancing. The four override combinations are run against a programmed code that differs from both forced codes. Complex mode is run with distinct I and Q words and the swap bit is toggled between pairs, so pairing order, one-pair latency and swap timing can each be observed.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_DDS      = 4'h0,
    SRC_PAT      = 4'h1,
    SRC_DMA      = 4'h2,
    SRC_ZERO     = 4'h3,
    SRC_PN7_INV  = 4'h4,
    SRC_PN15_INV = 4'h5,
    SRC_PN7      = 4'h6,
    SRC_PN15     = 4'h7,
    SRC_LPBK     = 4'h8,
    SRC_PNX      = 4'h9,
    SRC_NRAMP    = 4'hA,
    SRC_WRAMP    = 4'hB
  } src_e;

  localparam int PN7_ORDER  = 7;
  localparam int PN7_TAP    = 6;
  localparam int PN15_ORDER = 15;
  localparam int PN15_TAP   = 14;
endpackage

// File: rtl/dac_src_prbs.sv
module dac_src_prbs #(
  parameter int ORDER = 7,
  parameter int TAP   = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [DW-1:0] sample
);
  localparam int PAD = DW - ORDER;

  logic [ORDER-1:0] state;
  logic             fb;

  assign fb     = state[ORDER-1] ^ state[TAP-1];
  assign sample = {{PAD{1'b0}}, state};

  always_ff @(posedge clk) begin
    if (rst)       state <= '1;
    else if (step) state <= {state[ORDER-2:0], fb};
  end

  // R5 / R6: a maximal-length register seeded non-zero never locks up at zero
  assert_prbs_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  // R12: the register moves only on a valid sample
  assert_prbs_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
endmodule

// File: rtl/dac_src_ramp.sv
module dac_src_ramp #(
  parameter int DW  = 16,
  parameter int NIB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [DW-1:0] nib_sample,
  output logic [DW-1:0] wide_sample
);
  localparam int NNIB = DW / NIB;

  logic [NIB-1:0] cnt_n;
  logic [DW-1:0]  cnt_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_n <= '0;
      cnt_w <= '0;
    end else if (step) begin
      cnt_n <= cnt_n + 1'b1;
      cnt_w <= cnt_w + 1'b1;
    end
  end

  for (genvar g = 0; g < NNIB; g++) begin : g_nib
    assign nib_sample[g*NIB +: NIB] = cnt_n;
  end
  assign wide_sample = cnt_w;

  // R8: the wide count wraps from all ones back to zero
  assert_wide_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_w == '1) |=> cnt_w == '0);
  // R7: nibble count and the low nibble of the wide count stay in step
  assert_nib_track_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_n == cnt_w[NIB-1:0]);
endmodule

// File: rtl/dac_src_iq.sv
module dac_src_iq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          iq_mode,
  input  logic          iq_swap,
  input  logic [DW-1:0] din,
  output logic          out_valid,
  output logic [DW-1:0] dout
);
  logic          phase;
  logic [DW-1:0] hold_i, pair_i, pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
      phase     <= 1'b0;
      hold_i    <= '0;
      pair_i    <= '0;
      pair_q    <= '0;
    end else begin
      out_valid <= valid;
      if (valid) begin
        if (!iq_mode) begin
          dout  <= din;
          phase <= 1'b0;
        end else begin
          if (!phase) begin
            hold_i <= din;
            dout   <= iq_swap ? pair_q : pair_i;
          end else begin
            pair_i <= hold_i;
            pair_q <= din;
            dout   <= iq_swap ? pair_i : pair_q;
          end
          phase <= ~phase;
        end
      end else if (!iq_mode) begin
        phase <= 1'b0;
      end
    end
  end

  // R13: outside complex mode the pair position is back at I
  assert_phase_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !iq_mode |=> !phase);
  // R14: swap has no effect in real mode
  assert_real_pass_R14: assert property (@(posedge clk) disable iff (rst)
    (valid && !iq_mode) |=> dout == $past(din));
endmodule

// File: rtl/dac_src_sel.sv
module dac_src_sel
  import dac_src_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] sel,
  input  logic             ovr_lpbk,
  input  logic             ovr_pnx,
  input  logic [DW-1:0]    pat_a,
  input  logic [DW-1:0]    pat_b,
  input  logic [DW-1:0]    dds_data,
  input  logic [DW-1:0]    dma_data,
  input  logic [DW-1:0]    lpbk_data,
  input  logic [DW-1:0]    pnx_data,
  input  logic             iq_mode,
  input  logic             iq_swap,
  output logic             out_valid,
  output logic [DW-1:0]    out_data
);
  logic [SEL_W-1:0] eff_sel;
  logic [DW-1:0]    pn7_s, pn15_s, nramp_s, wramp_s, mux_s;
  logic             pat_phase;

  always_comb begin
    if (ovr_lpbk && !ovr_pnx)      eff_sel = SRC_LPBK;
    else if (ovr_pnx && !ovr_lpbk) eff_sel = SRC_PNX;
    else                           eff_sel = sel;
  end

  always_ff @(posedge clk) begin
    if (rst)           pat_phase <= 1'b0;
    else if (in_valid) pat_phase <= ~pat_phase;
  end

  dac_src_prbs #(.ORDER(PN7_ORDER), .TAP(PN7_TAP), .DW(DW)) i_pn7 (
    .clk(clk), .rst(rst), .step(in_valid), .sample(pn7_s));

  dac_src_prbs #(.ORDER(PN15_ORDER), .TAP(PN15_TAP), .DW(DW)) i_pn15 (
    .clk(clk), .rst(rst), .step(in_valid), .sample(pn15_s));

  dac_src_ramp #(.DW(DW), .NIB(4)) i_ramp (
    .clk(clk), .rst(rst), .step(in_valid),
    .nib_sample(nramp_s), .wide_sample(wramp_s));

  always_comb begin
    case (eff_sel)
      SRC_DDS:      mux_s = dds_data;
      SRC_PAT:      mux_s = pat_phase ? pat_b : pat_a;
      SRC_DMA:      mux_s = dma_data;
      SRC_PN7_INV:  mux_s = ~pn7_s;
      SRC_PN15_INV: mux_s = ~pn15_s;
      SRC_PN7:      mux_s = pn7_s;
      SRC_PN15:     mux_s = pn15_s;
      SRC_LPBK:     mux_s = lpbk_data;
      SRC_PNX:      mux_s = pnx_data;
      SRC_NRAMP:    mux_s = nramp_s;
      SRC_WRAMP:    mux_s = wramp_s;
      default:      mux_s = '0;
    endcase
  end

  dac_src_iq #(.DW(DW)) i_iq (
    .clk(clk), .rst(rst), .valid(in_valid), .iq_mode(iq_mode),
    .iq_swap(iq_swap), .din(mux_s),
    .out_valid(out_valid), .dout(out_data));

  // R2: no valid sample, no change at the output
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && !out_valid));
  // R9: a lone loopback override wins over the programmed code
  assert_lpbk_ovr_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovr_lpbk && !ovr_pnx && !iq_mode) |=> out_data == $past(lpbk_data));
  // R10: a lone external-sequence override wins over the programmed code
  assert_pnx_ovr_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovr_pnx && !ovr_lpbk && !iq_mode) |=> out_data == $past(pnx_data));
  // R11: both overrides together leave the programmed zero code in force
  assert_both_ovr_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovr_pnx && ovr_lpbk && !iq_mode && sel == SRC_ZERO) |=> out_data == '0);
  // R3: unassigned codes produce zero
  assert_spare_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ovr_pnx && !ovr_lpbk && !iq_mode && sel >= 4'hC) |=> out_data == '0);
endmodule

// File: tb/test_dac_src_sel.sv
`timescale 1ns/1ps
module test_dac_src_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  sel = '0;
  logic        ovr_lpbk = 1'b0, ovr_pnx = 1'b0;
  logic [15:0] pat_a = 16'h1234, pat_b = 16'hBEEF;
  logic [15:0] dds_data = '0, dma_data = '0, lpbk_data = '0, pnx_data = '0;
  logic        iq_mode = 1'b0, iq_swap = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int          m_pn7, m_pn15, m_nib, m_wide;
  bit          m_pat;
  logic [15:0] cq[$];
  logic        exp_v;
  logic [15:0] exp_d;
  string       tag;

  always #2 clk = ~clk;

  dac_src_sel i_dac_src_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel(sel),
    .ovr_lpbk(ovr_lpbk), .ovr_pnx(ovr_pnx), .pat_a(pat_a), .pat_b(pat_b),
    .dds_data(dds_data), .dma_data(dma_data), .lpbk_data(lpbk_data),
    .pnx_data(pnx_data), .iq_mode(iq_mode), .iq_swap(iq_swap),
    .out_valid(out_valid), .out_data(out_data));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic model_reset();
    m_pn7 = 7'h7F; m_pn15 = 15'h7FFF; m_nib = 0; m_wide = 0; m_pat = 0;
    cq.delete(); exp_v = 0; exp_d = '0;
  endtask

  function automatic logic [15:0] pick(input logic [3:0] code);
    logic [15:0] n;
    n = {4{m_nib[3:0]}};
    case (code)
      4'h0: return dds_data;
      4'h1: return m_pat ? pat_b : pat_a;
      4'h2: return dma_data;
      4'h4: return ~16'(m_pn7);
      4'h5: return ~16'(m_pn15);
      4'h6: return 16'(m_pn7);
      4'h7: return 16'(m_pn15);
      4'h8: return lpbk_data;
      4'h9: return pnx_data;
      4'hA: return n;
      4'hB: return 16'(m_wide);
      default: return 16'h0;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_v || out_data !== exp_d) begin
      fails++;
      $display("FAIL %s: actual v=%0b d=%h expected v=%0b d=%h",
               tag, out_valid, out_data, exp_v, exp_d);
    end
  endtask

  // drive one cycle at a negedge, predict, then compare at the next negedge
  task automatic cyc(input logic v, input logic [3:0] s, input logic [15:0] d);
    logic [3:0]  eff;
    logic [15:0] smp;
    in_valid = v; sel = s;
    dds_data = d; dma_data = d ^ 16'h5A5A; lpbk_data = d ^ 16'hF00F; pnx_data = ~d;
    exp_v = v;
    if (v) begin
      if (ovr_lpbk && !ovr_pnx)      eff = 4'h8;
      else if (ovr_pnx && !ovr_lpbk) eff = 4'h9;
      else                           eff = s;
      smp = pick(eff);
      if (!iq_mode) exp_d = smp;
      else begin
        int k, m;
        cq.push_back(smp);
        k = cq.size() - 1; m = k / 2;
        if (m == 0) exp_d = '0;
        else if ((k % 2) == 0) exp_d = iq_swap ? cq[2*m-1] : cq[2*m-2];
        else                   exp_d = iq_swap ? cq[2*m-2] : cq[2*m-1];
      end
      m_pn7  = ((m_pn7 << 1) | (((m_pn7 >> 6) ^ (m_pn7 >> 5)) & 1)) & 'h7F;
      m_pn15 = ((m_pn15 << 1) | (((m_pn15 >> 14) ^ (m_pn15 >> 13)) & 1)) & 'h7FFF;
      m_nib  = (m_nib + 1) % 16;
      m_wide = (m_wide + 1) % 65536;
      m_pat  = ~m_pat;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; iq_mode = 0; iq_swap = 0; ovr_lpbk = 0; ovr_pnx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    tag = "R1 reset state";
    compare();
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    tag = "R3 pass-through and spare codes";
    for (int i = 0; i < 4; i++) cyc(1, 4'h0, 16'h1000 + 16'(i * 37));
    cyc(1, 4'h2, 16'h2222); cyc(1, 4'h2, 16'h3141);
    cyc(1, 4'h3, 16'hAAAA);
    cyc(1, 4'h8, 16'h4321); cyc(1, 4'h9, 16'h0F0F);
    for (int c = 12; c < 16; c++) cyc(1, 4'(c), 16'hFFFF);

    tag = "R2 hold without valid";
    cyc(1, 4'h0, 16'h7777);
    cyc(0, 4'h2, 16'h1111); cyc(0, 4'hB, 16'h2468); cyc(1, 4'h0, 16'h0001);

    tag = "R4 pattern alternation";
    for (int i = 0; i < 6; i++) cyc(1, 4'h1, 16'(i));
    cyc(0, 4'h1, 16'h0); cyc(1, 4'h1, 16'h0);

    tag = "R5 pn7 true and inverted";
    for (int i = 0; i < 140; i++) cyc(1, (i % 3 == 0) ? 4'h4 : 4'h6, 16'(i));
    tag = "R6 pn15 true and inverted";
    for (int i = 0; i < 140; i++) cyc(1, (i % 3 == 0) ? 4'h5 : 4'h7, 16'(i));

    tag = "R12 generators advance while unselected";
    for (int i = 0; i < 9; i++) cyc(1, 4'h0, 16'(i * 5));
    cyc(1, 4'h6, 16'h0); cyc(1, 4'hA, 16'h0); cyc(1, 4'h1, 16'h0); cyc(1, 4'h7, 16'h0);

    tag = "R7 nibble ramp";
    for (int i = 0; i < 40; i++) cyc(1, 4'hA, 16'h0);

    tag = "R8 wide ramp wrap";
    for (int i = 0; i < 65600; i++) cyc(1, 4'hB, 16'h0);

    tag = "R9 loopback override";
    ovr_lpbk = 1; cyc(1, 4'h3, 16'h1357); cyc(1, 4'hB, 16'h2468);
    tag = "R10 pnx override";
    ovr_lpbk = 0; ovr_pnx = 1; cyc(1, 4'h3, 16'h1357); cyc(1, 4'h0, 16'h9999);
    tag = "R11 both overrides ignored";
    ovr_lpbk = 1; cyc(1, 4'h3, 16'h1357); cyc(1, 4'h2, 16'h8642); cyc(1, 4'h0, 16'hC0DE);
    ovr_lpbk = 0; ovr_pnx = 0;

    tag = "R14 swap ignored in real mode";
    iq_swap = 1;
    for (int i = 0; i < 4; i++) cyc(1, 4'h0, 16'hA000 + 16'(i));
    iq_swap = 0;

    do_reset();
    tag = "R13 complex pairing";
    iq_mode = 1;
    for (int i = 0; i < 8; i++) cyc(1, 4'h0, 16'h5000 + 16'(i));
    cyc(0, 4'h0, 16'h0);
    tag = "R14 complex swap";
    iq_swap = 1;
    for (int i = 8; i < 14; i++) cyc(1, 4'h0, 16'h5000 + 16'(i));
    iq_swap = 0;
    for (int i = 14; i < 18; i++) cyc(1, 4'h0, 16'h5000 + 16'(i));
    tag = "R13 complex with generator";
    for (int i = 0; i < 8; i++) cyc(1, 4'hB, 16'h0);

    summary();
    $finish;
  end
endmodule